// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Burst Counters

A 16-bit-wide RAM with two fully independent ports, left and right. Each port runs on its own clock. Both ports can read or write any word in the same cycle, and they may use the same word. Each port registers its address, write data and control inputs on the rising edge of its clock.

Each port has its own address counter for burst access. The counter can take the external address, step forward by one word, or return to zero. The word that the port accesses is always the counter's new value. Each port also has a mode input. In flow-through mode, read data appears one cycle after the request is registered. In pipelined mode, an output register adds one more cycle.

Per-byte output-drive flags stand in for a tri-state data bus. A drive flag depends on the request registered earlier and on an asynchronous output-enable input. The depth is set by a parameter. A 14-bit address gives 16K words and a 15-bit address gives 32K words. The default is a smaller array.

Top module: `dpr_sync_ram`

## Requirements
- R1: A port is selected only when `cs_*_n` is 0 and `cs_*` is 1 at a capturing edge. An unselected cycle writes no data and drives no output byte.
- R2: With `pipe_*`=0, a read registered at clock edge k presents its data on `dout_*` after edge k+1.
- R3: With `pipe_*`=1, a read registered at edge k presents its data after edge k+2. After edge k+1 the outputs still show the previous cycle's result.
- R4: Byte enable `be_*[1]` covers bits 15:8 and `be_*[0]` covers bits 7:0. A write changes only the enabled bytes. A read drives only the enabled bytes, and a byte that is not driven reads as 0 on `dout_*`.
- R5: `dout_en_*[j]` is 1 only when the read registered one cycle earlier (two cycles in pipelined mode) enabled byte j and `oe_*_n` is 0. `oe_*_n` acts at once, without a clock edge.
- R6: Each counter takes its controls in fixed priority: `clr_*` gives zero, then `ld_*` gives the external address, then `adv_*` gives the counter plus one. With none of them asserted, the counter holds. The access uses the resulting address.
- R7: Stepping from the top address 2**ADDR_W-1 wraps the counter to 0.
- R8: Data written by either port can be read by either port, and both ports can work on different words in the same cycle.
- R9: A read in the same cycle as the other port's write to that word returns the old data. Reads from the next cycle on return the new data.
- R10: After reset, `dout_*` and `dout_en_*` are 0 and each counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port asynchronous reset, active low |
| cs_l_n | input | 1 | Left select, active low |
| cs_l | input | 1 | Left select, active high |
| we_l | input | 1 | Left write (1) or read (0) |
| be_l | input | 2 | Left byte enables, bit 1 = upper byte |
| ld_l | input | 1 | Left counter load from addr_l |
| adv_l | input | 1 | Left counter step |
| clr_l | input | 1 | Left counter clear |
| oe_l_n | input | 1 | Left asynchronous output enable, active low |
| pipe_l | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| addr_l | input | ADDR_W | Left external address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data, undriven bytes 0 |
| dout_en_l | output | DATA_W/8 | Left per-byte drive flags |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port asynchronous reset, active low |
| cs_r_n | input | 1 | Right select, active low |
| cs_r | input | 1 | Right select, active high |
| we_r | input | 1 | Right write (1) or read (0) |
| be_r | input | 2 | Right byte enables, bit 1 = upper byte |
| ld_r | input | 1 | Right counter load from addr_r |
| adv_r | input | 1 | Right counter step |
| clr_r | input | 1 | Right counter clear |
| oe_r_n | input | 1 | Right asynchronous output enable, active low |
| pipe_r | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| addr_r | input | ADDR_W | Right external address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data, undriven bytes 0 |
| dout_en_r | output | DATA_W/8 | Right per-byte drive flags |

## Verification
A wrong counter value shows up on the next read through that counter. The bytes from the wrong word appear on `dout_*` one cycle after that read is registered, or two cycles in pipelined mode. A stale last-writer tag makes a port return the other bank's copy of a byte. This shows up the first time the other port reads that word after a write. Faults in the select, write/read or byte-mask path show up on `dout_en_*` in the cycle the data would appear.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
   localparam int unsigned LANE_W = 8;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_STEP = 2'd1,
      CNT_LOAD = 2'd2,
      CNT_ZERO = 2'd3
   } cnt_op_e;

   // Fixed priority: clear over load over step.
   function automatic cnt_op_e cnt_pick(input logic zero, input logic load, input logic step);
      cnt_op_e op;
      if (zero)      op = CNT_ZERO;
      else if (load) op = CNT_LOAD;
      else if (step) op = CNT_STEP;
      else           op = CNT_HOLD;
      return op;
   endfunction
endpackage

// File: rtl/dpr_port_front.sv
`timescale 1ns/1ps
// Input registers and burst address counter of one port.
module dpr_port_front
   import dpr_pkg::*;
#(
   parameter int AW    = 8,
   parameter int LANES = 2,
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cs,
   input  logic             we,
   input  logic [LANES-1:0] be,
   input  logic             ld,
   input  logic             adv,
   input  logic             clr,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    din,
   output logic [AW-1:0]    acc_addr,
   output logic [LANES-1:0] wr_mask,
   output logic [LANES-1:0] rd_mask,
   output logic [DW-1:0]    wdata
);
   logic             sel_q, we_q;
   logic [LANES-1:0] be_q;
   cnt_op_e          op_q;
   logic [AW-1:0]    addr_q, cnt_q, next_addr;
   logic [DW-1:0]    din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         we_q   <= 1'b0;
         be_q   <= '0;
         op_q   <= CNT_HOLD;
         addr_q <= '0;
         din_q  <= '0;
         cnt_q  <= '0;
      end else begin
         sel_q  <= ~cs_n & cs;
         we_q   <= we;
         be_q   <= be;
         op_q   <= cnt_pick(clr, ld, adv);
         addr_q <= addr;
         din_q  <= din;
         cnt_q  <= next_addr;
      end
   end

   always_comb begin
      unique case (op_q)
         CNT_ZERO: next_addr = '0;
         CNT_LOAD: next_addr = addr_q;
         CNT_STEP: next_addr = cnt_q + AW'(1);
         default:  next_addr = cnt_q;
      endcase
   end

   assign acc_addr = next_addr;
   assign wr_mask  = be_q & {LANES{sel_q & we_q}};
   assign rd_mask  = be_q & {LANES{sel_q & ~we_q}};
   assign wdata    = din_q;
endmodule

// File: rtl/dpr_lvt_store.sv
`timescale 1ns/1ps
// Two-clock storage: one bank per writing port per byte lane, and a
// last-writer tag pair per word and lane selecting the bank to read.
module dpr_lvt_store
   import dpr_pkg::*;
#(
   parameter int AW    = 8,
   parameter int LANES = 2,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << AW
) (
   input  logic             clk_a,
   input  logic [AW-1:0]    a_addr,
   input  logic [LANES-1:0] a_wmask,
   input  logic [DW-1:0]    a_wdata,
   output logic [DW-1:0]    a_rdata,
   input  logic             clk_b,
   input  logic [AW-1:0]    b_addr,
   input  logic [LANES-1:0] b_wmask,
   input  logic [DW-1:0]    b_wdata,
   output logic [DW-1:0]    b_rdata
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] bank_a [DEPTH];
      logic [LANE_W-1:0] bank_b [DEPTH];
      logic              tag_a  [DEPTH];
      logic              tag_b  [DEPTH];
      logic [LANE_W-1:0] rd_a, rd_b;

      // Port a write makes the tags equal; port b write makes them differ.
      always_ff @(posedge clk_a) begin
         if (a_wmask[j]) begin
            bank_a[a_addr] <= a_wdata[j*LANE_W +: LANE_W];
            tag_a[a_addr]  <= tag_b[a_addr];
         end
         rd_a <= (tag_a[a_addr] ^ tag_b[a_addr]) ? bank_b[a_addr] : bank_a[a_addr];
      end

      always_ff @(posedge clk_b) begin
         if (b_wmask[j]) begin
            bank_b[b_addr] <= b_wdata[j*LANE_W +: LANE_W];
            tag_b[b_addr]  <= ~tag_a[b_addr];
         end
         rd_b <= (tag_a[b_addr] ^ tag_b[b_addr]) ? bank_b[b_addr] : bank_a[b_addr];
      end

      assign a_rdata[j*LANE_W +: LANE_W] = rd_a;
      assign b_rdata[j*LANE_W +: LANE_W] = rd_b;
   end
endmodule

// File: rtl/dpr_out_stage.sv
`timescale 1ns/1ps
// Flow-through / pipelined selection and per-byte drive gating.
module dpr_out_stage
   import dpr_pkg::*;
#(
   parameter int LANES = 2,
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pipe,
   input  logic             oe_n,
   input  logic [LANES-1:0] rd_mask,
   input  logic [DW-1:0]    rdata,
   output logic [DW-1:0]    dout,
   output logic [LANES-1:0] dout_en
);
   logic [LANES-1:0] m1_q, m2_q, mask;
   logic [DW-1:0]    d2_q, data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_q <= '0;
         m2_q <= '0;
         d2_q <= '0;
      end else begin
         m1_q <= rd_mask;
         m2_q <= m1_q;
         d2_q <= rdata;
      end
   end

   assign mask = pipe ? m2_q : m1_q;
   assign data = pipe ? d2_q : rdata;

   for (genvar j = 0; j < LANES; j++) begin : g_drv
      assign dout_en[j] = mask[j] & ~oe_n;
      assign dout[j*LANE_W +: LANE_W] = dout_en[j] ? data[j*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/dpr_sync_ram.sv
`timescale 1ns/1ps
module dpr_sync_ram
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk_l,
   input  logic              rst_l_n,
   input  logic              cs_l_n,
   input  logic              cs_l,
   input  logic              we_l,
   input  logic [LANES-1:0]  be_l,
   input  logic              ld_l,
   input  logic              adv_l,
   input  logic              clr_l,
   input  logic              oe_l_n,
   input  logic              pipe_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [DATA_W-1:0] din_l,
   output logic [DATA_W-1:0] dout_l,
   output logic [LANES-1:0]  dout_en_l,
   input  logic              clk_r,
   input  logic              rst_r_n,
   input  logic              cs_r_n,
   input  logic              cs_r,
   input  logic              we_r,
   input  logic [LANES-1:0]  be_r,
   input  logic              ld_r,
   input  logic              adv_r,
   input  logic              clr_r,
   input  logic              oe_r_n,
   input  logic              pipe_r,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [DATA_W-1:0] din_r,
   output logic [DATA_W-1:0] dout_r,
   output logic [LANES-1:0]  dout_en_r
);
   if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin : g_bad_width
      $error("DATA_W must be a positive whole number of bytes");
   end
   if (ADDR_W < 2 || ADDR_W > 15) begin : g_bad_depth
      $error("ADDR_W must lie between 2 and 15");
   end

   logic [ADDR_W-1:0] acc_l, acc_r;
   logic [LANES-1:0]  wm_l, wm_r, rm_l, rm_r;
   logic [DATA_W-1:0] wd_l, wd_r, rd_l, rd_r;

   dpr_port_front #(.AW(ADDR_W), .LANES(LANES)) u_front_l (
      .clk(clk_l), .rst_n(rst_l_n), .cs_n(cs_l_n), .cs(cs_l), .we(we_l), .be(be_l),
      .ld(ld_l), .adv(adv_l), .clr(clr_l), .addr(addr_l), .din(din_l),
      .acc_addr(acc_l), .wr_mask(wm_l), .rd_mask(rm_l), .wdata(wd_l));

   dpr_port_front #(.AW(ADDR_W), .LANES(LANES)) u_front_r (
      .clk(clk_r), .rst_n(rst_r_n), .cs_n(cs_r_n), .cs(cs_r), .we(we_r), .be(be_r),
      .ld(ld_r), .adv(adv_r), .clr(clr_r), .addr(addr_r), .din(din_r),
      .acc_addr(acc_r), .wr_mask(wm_r), .rd_mask(rm_r), .wdata(wd_r));

   dpr_lvt_store #(.AW(ADDR_W), .LANES(LANES)) u_store (
      .clk_a(clk_l), .a_addr(acc_l), .a_wmask(wm_l), .a_wdata(wd_l), .a_rdata(rd_l),
      .clk_b(clk_r), .b_addr(acc_r), .b_wmask(wm_r), .b_wdata(wd_r), .b_rdata(rd_r));

   dpr_out_stage #(.LANES(LANES)) u_out_l (
      .clk(clk_l), .rst_n(rst_l_n), .pipe(pipe_l), .oe_n(oe_l_n),
      .rd_mask(rm_l), .rdata(rd_l), .dout(dout_l), .dout_en(dout_en_l));

   dpr_out_stage #(.LANES(LANES)) u_out_r (
      .clk(clk_r), .rst_n(rst_r_n), .pipe(pipe_r), .oe_n(oe_r_n),
      .rd_mask(rm_r), .rdata(rd_r), .dout(dout_r), .dout_en(dout_en_r));
endmodule

// File: rtl/dpr_sync_ram_chk.sv
`timescale 1ns/1ps
module dpr_sync_ram_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk_l,
   input logic              rst_l_n,
   input logic              cs_l_n,
   input logic              cs_l,
   input logic              we_l,
   input logic [LANES-1:0]  be_l,
   input logic              oe_l_n,
   input logic              pipe_l,
   input logic [DATA_W-1:0] dout_l,
   input logic [LANES-1:0]  dout_en_l,
   input logic              clk_r,
   input logic              rst_r_n,
   input logic              cs_r_n,
   input logic              cs_r,
   input logic              we_r,
   input logic [LANES-1:0]  be_r,
   input logic              oe_r_n,
   input logic              pipe_r,
   input logic [DATA_W-1:0] dout_r,
   input logic [LANES-1:0]  dout_en_r
);
   logic [DATA_W-1:0] bits_l, bits_r;
   for (genvar j = 0; j < LANES; j++) begin : g_exp
      assign bits_l[j*8 +: 8] = {8{dout_en_l[j]}};
      assign bits_r[j*8 +: 8] = {8{dout_en_r[j]}};
   end

   p_hiz_oe_r5_l: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      oe_l_n |-> dout_en_l == '0);
   p_hiz_oe_r5_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      oe_r_n |-> dout_en_r == '0);

   p_zero_fill_r4_l: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (dout_l & ~bits_l) == '0);
   p_zero_fill_r4_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      (dout_r & ~bits_r) == '0);

   p_flow_lat_r2_l: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      ($past(rst_l_n, 2) && !pipe_l && !oe_l_n && $past(!cs_l_n && cs_l && !we_l, 2))
      |-> dout_en_l == $past(be_l, 2));
   p_flow_lat_r2_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      ($past(rst_r_n, 2) && !pipe_r && !oe_r_n && $past(!cs_r_n && cs_r && !we_r, 2))
      |-> dout_en_r == $past(be_r, 2));

   p_pipe_lat_r3_l: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      ($past(rst_l_n, 3) && pipe_l && !oe_l_n && $past(!cs_l_n && cs_l && !we_l, 3))
      |-> dout_en_l == $past(be_l, 3));
   p_pipe_lat_r3_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      ($past(rst_r_n, 3) && pipe_r && !oe_r_n && $past(!cs_r_n && cs_r && !we_r, 3))
      |-> dout_en_r == $past(be_r, 3));

   p_nosel_r1_l: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      ($past(rst_l_n, 2) && !pipe_l && $past(!(!cs_l_n && cs_l) || we_l, 2))
      |-> dout_en_l == '0);
   p_nosel_r1_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      ($past(rst_r_n, 2) && !pipe_r && $past(!(!cs_r_n && cs_r) || we_r, 2))
      |-> dout_en_r == '0);
endmodule

bind dpr_sync_ram dpr_sync_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk_l(clk_l), .rst_l_n(rst_l_n), .cs_l_n(cs_l_n), .cs_l(cs_l), .we_l(we_l),
   .be_l(be_l), .oe_l_n(oe_l_n), .pipe_l(pipe_l), .dout_l(dout_l), .dout_en_l(dout_en_l),
   .clk_r(clk_r), .rst_r_n(rst_r_n), .cs_r_n(cs_r_n), .cs_r(cs_r), .we_r(we_r),
   .be_r(be_r), .oe_r_n(oe_r_n), .pipe_r(pipe_r), .dout_r(dout_r), .dout_en_r(dout_en_r));

// File: tb/tb_dpr_sync_ram.sv
`timescale 1ns/1ps
module tb_dpr_sync_ram;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk_l = 1'b0, clk_r = 1'b0;
   logic rst_l_n = 1'b0, rst_r_n = 1'b0;
   logic cs_l_n = 1'b1, cs_l = 1'b0, we_l = 1'b0, ld_l = 1'b0, adv_l = 1'b0, clr_l = 1'b0;
   logic cs_r_n = 1'b1, cs_r = 1'b0, we_r = 1'b0, ld_r = 1'b0, adv_r = 1'b0, clr_r = 1'b0;
   logic oe_l_n = 1'b0, oe_r_n = 1'b0, pipe_l = 1'b0, pipe_r = 1'b0;
   logic [1:0] be_l = 2'b00, be_r = 2'b00;
   logic [AW-1:0] addr_l = '0, addr_r = '0;
   logic [DW-1:0] din_l = '0, din_r = '0;
   logic [DW-1:0] dout_l, dout_r;
   logic [1:0] dout_en_l, dout_en_r;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk_l = ~clk_l;
   always #2.5 clk_r = ~clk_r;

   dpr_sync_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk_l(clk_l), .rst_l_n(rst_l_n), .cs_l_n(cs_l_n), .cs_l(cs_l), .we_l(we_l),
      .be_l(be_l), .ld_l(ld_l), .adv_l(adv_l), .clr_l(clr_l), .oe_l_n(oe_l_n),
      .pipe_l(pipe_l), .addr_l(addr_l), .din_l(din_l), .dout_l(dout_l), .dout_en_l(dout_en_l),
      .clk_r(clk_r), .rst_r_n(rst_r_n), .cs_r_n(cs_r_n), .cs_r(cs_r), .we_r(we_r),
      .be_r(be_r), .ld_r(ld_r), .adv_r(adv_r), .clr_r(clr_r), .oe_r_n(oe_r_n),
      .pipe_r(pipe_r), .addr_r(addr_r), .din_r(din_r), .dout_r(dout_r), .dout_en_r(dout_en_r));

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk_l);
      @(negedge clk_l);
   endtask

   task automatic set_l(input logic sel, input logic w, input logic [1:0] be,
                        input logic ld, input logic adv, input logic clr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs_l_n = ~sel; cs_l = sel; we_l = w; be_l = be;
      ld_l = ld; adv_l = adv; clr_l = clr; addr_l = a; din_l = d;
   endtask

   task automatic set_r(input logic sel, input logic w, input logic [1:0] be,
                        input logic ld, input logic adv, input logic clr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs_r_n = ~sel; cs_r = sel; we_r = w; be_r = be;
      ld_r = ld; adv_r = adv; clr_r = clr; addr_r = a; din_r = d;
   endtask

   task automatic idle();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      set_r(0, 0, 2'b00, 0, 0, 0, '0, '0);
   endtask

   task automatic wr_l(input logic [AW-1:0] a, input logic [1:0] be, input logic [DW-1:0] d);
      set_l(1, 1, be, 1, 0, 0, a, d);
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
   endtask

   task automatic rd_l(input string tag, input logic [AW-1:0] a, input logic [1:0] be,
                       input logic [DW-1:0] exp_d, input logic [1:0] exp_en);
      set_l(1, 0, be, 1, 0, 0, a, '0);
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      tick();
      check({tag, " data"}, dout_l, exp_d);
      check({tag, " drive"}, {14'd0, dout_en_l}, {14'd0, exp_en});
   endtask

   task automatic t_reset();
      check("R10 left data in reset", dout_l, '0);
      check("R10 left drive in reset", {14'd0, dout_en_l}, '0);
      rst_l_n = 1'b1; rst_r_n = 1'b1;
      tick();
      check("R10 right data after reset", dout_r, '0);
      check("R10 right drive after reset", {14'd0, dout_en_r}, '0);
      // Counter is zero: a held-address write lands on word 0.
      set_l(1, 1, 2'b11, 0, 0, 0, 8'h77, 16'h0A0A);
      tick();
      idle();
      rd_l("R10 counter zero after reset", 8'd0, 2'b11, 16'h0A0A, 2'b11);
   endtask

   task automatic t_cross_flow();
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd5, 16'h1234);
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      set_r(1, 0, 2'b11, 1, 0, 0, 8'd5, '0);
      tick();
      set_r(0, 0, 2'b00, 0, 0, 0, '0, '0);
      tick();
      check("R2 R8 right flow read of left write", dout_r, 16'h1234);
      check("R2 right flow drive", {14'd0, dout_en_r}, 16'h0003);
   endtask

   task automatic t_pipe();
      pipe_r = 1'b1;
      tick();
      set_r(1, 0, 2'b11, 1, 0, 0, 8'd5, '0);
      tick();
      set_r(0, 0, 2'b00, 0, 0, 0, '0, '0);
      tick();
      check("R3 pipelined drive one cycle early", {14'd0, dout_en_r}, 16'h0000);
      tick();
      check("R3 pipelined data", dout_r, 16'h1234);
      check("R3 pipelined drive", {14'd0, dout_en_r}, 16'h0003);
      pipe_r = 1'b0;
      tick();
   endtask

   task automatic t_bytes();
      wr_l(8'd6, 2'b11, 16'h1122);
      wr_l(8'd6, 2'b10, 16'hFFEE);
      wr_l(8'd6, 2'b00, 16'h9999);
      rd_l("R4 upper-byte write merge", 8'd6, 2'b11, 16'hFF22, 2'b11);
      rd_l("R4 lower-byte read", 8'd6, 2'b01, 16'h0022, 2'b01);
      rd_l("R4 upper-byte read", 8'd6, 2'b10, 16'hFF00, 2'b10);
   endtask

   task automatic t_oe();
      set_l(1, 0, 2'b11, 1, 0, 0, 8'd6, '0);
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      oe_l_n = 1'b1;
      tick();
      check("R5 output enable off data", dout_l, 16'h0000);
      check("R5 output enable off drive", {14'd0, dout_en_l}, 16'h0000);
      oe_l_n = 1'b0;
      #1;
      check("R5 output enable on without clock", dout_l, 16'hFF22);
      tick();
   endtask

   task automatic t_select();
      wr_l(8'd7, 2'b11, 16'h5555);
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd7, 16'h0F0F);
      cs_l_n = 1'b0; cs_l = 1'b0;
      tick();
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd7, 16'hF0F0);
      cs_l_n = 1'b1; cs_l = 1'b1;
      tick();
      set_l(1, 0, 2'b11, 1, 0, 0, 8'd7, '0);
      cs_l_n = 1'b1; cs_l = 1'b0;
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      tick();
      check("R1 unselected read drives nothing", {14'd0, dout_en_l}, 16'h0000);
      rd_l("R1 unselected writes ignored", 8'd7, 2'b11, 16'h5555, 2'b11);
   endtask

   task automatic t_counter();
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd10, 16'hD000); tick();
      set_l(1, 1, 2'b11, 0, 1, 0, 8'd99, 16'hD001); tick();
      set_l(1, 1, 2'b11, 0, 1, 0, 8'd99, 16'hD002); tick();
      set_l(1, 1, 2'b11, 1, 1, 1, 8'h55, 16'hD003); tick();
      set_l(1, 1, 2'b11, 1, 1, 0, 8'd20, 16'hD004); tick();
      set_l(1, 0, 2'b11, 0, 0, 0, 8'd33, '0); tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0); tick();
      check("R6 hold reads loaded address", dout_l, 16'hD004);
      rd_l("R6 load address", 8'd10, 2'b11, 16'hD000, 2'b11);
      rd_l("R6 first step", 8'd11, 2'b11, 16'hD001, 2'b11);
      rd_l("R6 second step", 8'd12, 2'b11, 16'hD002, 2'b11);
      rd_l("R6 clear beats load and step", 8'd0, 2'b11, 16'hD003, 2'b11);
   endtask

   task automatic t_wrap();
      set_l(1, 1, 2'b11, 1, 0, 0, 8'hFF, 16'hBEEF); tick();
      set_l(1, 1, 2'b11, 0, 1, 0, 8'd44, 16'hC0DE); tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      rd_l("R7 wrap to zero", 8'd0, 2'b11, 16'hC0DE, 2'b11);
      rd_l("R7 top word kept", 8'hFF, 2'b11, 16'hBEEF, 2'b11);
   endtask

   task automatic t_collide();
      wr_l(8'd30, 2'b11, 16'h1111);
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd30, 16'h2222);
      set_r(1, 0, 2'b11, 1, 0, 0, 8'd30, '0);
      tick();
      set_l(0, 0, 2'b00, 0, 0, 0, '0, '0);
      set_r(1, 0, 2'b11, 1, 0, 0, 8'd30, '0);
      tick();
      set_r(0, 0, 2'b00, 0, 0, 0, '0, '0);
      check("R9 same-cycle read returns old", dout_r, 16'h1111);
      tick();
      check("R9 next-cycle read returns new", dout_r, 16'h2222);
   endtask

   task automatic t_parallel();
      set_l(1, 1, 2'b11, 1, 0, 0, 8'd40, 16'hAB40);
      set_r(1, 1, 2'b11, 1, 0, 0, 8'd41, 16'hCD41);
      tick();
      set_l(1, 0, 2'b11, 1, 0, 0, 8'd41, '0);
      set_r(1, 0, 2'b11, 1, 0, 0, 8'd40, '0);
      tick();
      idle();
      tick();
      check("R8 left reads right write", dout_l, 16'hCD41);
      check("R8 right reads left write", dout_r, 16'hAB40);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #100000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual run still active expected finished");
      finish_run();
   end

   initial begin
      idle();
      tick();
      tick();
      t_reset();
      t_cross_flow();
      t_pipe();
      t_bytes();
      t_oe();
      t_select();
      t_counter();
      t_wrap();
      t_collide();
      t_parallel();
      finish_run();
   end
endmodule